// File: doc/BRIEF.md
# Memory Self-Test and Repair Controller

This block sits between a host and a square, word-addressed main array plus a small pool of spare elements. Each spare element holds one full line of storage, and it can stand in for either a faulty row or a faulty column. When reset is released, the block takes both memories and runs a March C- test. It tests every spare element first and the main array second. A spare element that shows any failing word is struck from the pool. Each main-array failure is given a spare in the same cycle it is detected, so the test takes the same number of cycles whether faults are present or not.

When the last test operation ends, the block raises a level interrupt, publishes its status flags, and opens the host port. From then on, each host access to a repaired row or column is steered to the spare that was assigned to it. The repair table is held only in flops. It is cleared by every reset and rebuilt by the next test.

Top module: `mbist_repair`

## Requirements
- R1: After reset is released, the test covers the spare storage first and then the main array. Each address receives 10 single-cycle operations. `st_done` rises after exactly 10*(NSPARE*2^LINE_BITS + 4^LINE_BITS) clock edges, whatever faults are present, and stays high until the next reset.
- R2: A spare element that has any failing word during the spare test is never assigned. The next usable element, in ascending index order, is used in its place.
- R3: While `host_ready` is low, host requests are ignored. They produce no `host_rvalid`, and host write data never reaches either memory.
- R4: A main-array failure that is not already covered takes the lowest-index free usable element as a column spare, unless R5 applies. The host address is {row, col}, with the row in the upper LINE_BITS. An access to column c at row r is sent to spare address {element, r}.
- R5: If the failing row already holds a column-repaired fault in a different column, the new fault takes a row spare. An access to that row at column c is sent to spare address {element, c}. A row match takes priority over a column match.
- R6: A failure at a cell that is already covered by an assigned spare does not use another spare.
- R7: If a failure needs a spare and no usable element is free, `st_unrep` is set and `st_pass` stays low.
- R8: After the test, `st_pass` = not `st_unrep`. `st_used` counts the assigned elements, and `st_repaired` is high when that count is non-zero.
- R9: `irq` rises in the same cycle as `st_done`. It stays high until the host pulses `irq_clr` high for a cycle.
- R10: A host read returns data with `host_rvalid` one cycle after the request. Data comes from the spare location if the address is remapped and from the main array otherwise. Each write strobes exactly one of `mem_we` or `spr_we`.
- R11: A reset clears all repair state. A fault-free run that follows a faulty run reports zero spares used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts the self-test when released |
| host_req | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2*LINE_BITS | Host word address {row, col} |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after the request |
| host_ready | output | 1 | High once the test has finished |
| irq | output | 1 | Test-complete interrupt, level-held |
| irq_clr | input | 1 | Write-1 clear of irq |
| st_done | output | 1 | Test finished |
| st_pass | output | 1 | Memory usable (no unrepairable fault) |
| st_repaired | output | 1 | At least one spare assigned |
| st_unrep | output | 1 | A fault found no free spare |
| st_used | output | clog2(NSPARE)+1 | Number of spares assigned |
| mem_addr | output | 2*LINE_BITS | Main array address |
| mem_we | output | 1 | Main array write strobe |
| mem_wdata | output | DW | Main array write data |
| mem_rdata | input | DW | Main array read data (asynchronous) |
| spr_addr | output | clog2(NSPARE)+LINE_BITS | Spare storage address {element, position} |
| spr_we | output | 1 | Spare storage write strobe |
| spr_wdata | output | DW | Spare storage write data |
| spr_rdata | input | DW | Spare storage read data (asynchronous) |

## Verification
The assertions check several rules on every cycle. The host port stays closed until the test is done. The done flag, the unrepairable flag and the interrupt are sticky in the ways the requirements define. Every allocation adds exactly one to the spare count. No allocation happens after the test. Only one memory is written at a time. The bench scenarios cover the rest, using a memory model with stuck-at bits in the main array and in the spare storage. Those scenarios show which spare element and which spare address each fault is steered to, how a bad spare is skipped, the row-over-column priority, the exhaustion of the pool, and that a later reset rebuilds the table from nothing.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

  typedef enum logic [1:0] {PH_SPARE, PH_MAIN, PH_DONE} phase_e;

  localparam logic [2:0] MARCH_LAST_ELEM = 3'd5;

  // March C- elements, indexed 0..5:
  // up w0 | up r0 w1 | up r1 w0 | down r0 w1 | down r1 w0 | up r0
  function automatic logic march_two_ops(input logic [2:0] e);
    return (e >= 3'd1) && (e <= 3'd4);
  endfunction

  function automatic logic march_down(input logic [2:0] e);
    return (e == 3'd3) || (e == 3'd4);
  endfunction

  function automatic logic march_first_is_read(input logic [2:0] e);
    return e != 3'd0;
  endfunction

  // Bit value of the first operation; the second operation writes its inverse
  function automatic logic march_first_val(input logic [2:0] e);
    return (e == 3'd2) || (e == 3'd4);
  endfunction

endpackage

// File: rtl/mbr_march_seq.sv
module mbr_march_seq #(
  parameter int AW  = 8,
  parameter int SAW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [AW-1:0]  t_addr,
  output logic           t_we,
  output logic           t_rd,
  output logic           t_val,
  output mbr_pkg::phase_e phase,
  output logic           t_end
);
  import mbr_pkg::*;

  localparam logic [AW-1:0] MAIN_LAST  = '1;
  localparam logic [AW-1:0] SPARE_LAST = AW'((2**SAW) - 1);

  logic [2:0]    elem;
  logic          op;
  logic [AW-1:0] addr;
  logic [AW-1:0] last;
  logic          addr_end;
  logic          op_last;
  logic [2:0]    elem_nx;
  logic [AW-1:0] start_nx;
  logic          active;

  always_comb begin
    active   = phase != PH_DONE;
    last     = (phase == PH_SPARE) ? SPARE_LAST : MAIN_LAST;
    addr_end = march_down(elem) ? (addr == '0) : (addr == last);
    op_last  = op || !march_two_ops(elem);
    elem_nx  = elem + 3'd1;
    start_nx = march_down(elem_nx) ? last : '0;
    t_addr   = addr;
    t_rd     = active && !op && march_first_is_read(elem);
    t_we     = active && (op || !march_first_is_read(elem));
    t_val    = op ? !march_first_val(elem) : march_first_val(elem);
    t_end    = (phase == PH_MAIN) && (elem == MARCH_LAST_ELEM) && addr_end && op_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_SPARE;
      elem  <= '0;
      op    <= 1'b0;
      addr  <= '0;
    end else if (active) begin
      if (!op_last) begin
        op <= 1'b1;
      end else begin
        op <= 1'b0;
        if (addr_end) begin
          if (elem == MARCH_LAST_ELEM) begin
            elem  <= '0;
            addr  <= '0;
            phase <= (phase == PH_SPARE) ? PH_MAIN : PH_DONE;
          end else begin
            elem <= elem_nx;
            addr <= start_nx;
          end
        end else begin
          addr <= march_down(elem) ? addr - 1'b1 : addr + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/mbr_spare_alloc.sv
module mbr_spare_alloc #(
  parameter int NSP = 4,
  parameter int LB  = 4,
  parameter int SIW = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spr_fail,
  input  logic [SIW-1:0]         spr_fail_elem,
  input  logic                   main_fail,
  input  logic [LB-1:0]          f_row,
  input  logic [LB-1:0]          f_col,
  output logic [NSP-1:0]         e_used,
  output logic [NSP-1:0]         e_isrow,
  output logic [NSP-1:0][LB-1:0] e_line,
  output logic                   alloc_fire,
  output logic                   alloc_miss,
  output logic                   unrep
);

  logic [NSP-1:0]         e_bad;
  logic [NSP-1:0][LB-1:0] e_orig;   // row of the fault that claimed a column spare
  logic                   covered;
  logic                   must_row;
  logic                   free_ok;
  logic [SIW-1:0]         pick;

  always_comb begin
    covered  = 1'b0;
    must_row = 1'b0;
    free_ok  = 1'b0;
    pick     = '0;
    for (int e = 0; e < NSP; e++) begin
      if (e_used[e]) begin
        if (e_isrow[e] && (e_line[e] == f_row)) covered = 1'b1;
        if (!e_isrow[e] && (e_line[e] == f_col)) covered = 1'b1;
        if (!e_isrow[e] && (e_orig[e] == f_row)) must_row = 1'b1;
      end
    end
    for (int e = NSP - 1; e >= 0; e--) begin
      if (!e_used[e] && !e_bad[e]) begin
        free_ok = 1'b1;
        pick    = SIW'(e);
      end
    end
    alloc_fire = main_fail && !covered && free_ok;
    alloc_miss = main_fail && !covered && !free_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_used  <= '0;
      e_isrow <= '0;
      e_bad   <= '0;
      e_line  <= '0;
      e_orig  <= '0;
      unrep   <= 1'b0;
    end else begin
      if (spr_fail) e_bad[spr_fail_elem] <= 1'b1;
      if (alloc_fire) begin
        e_used[pick]  <= 1'b1;
        e_isrow[pick] <= must_row;
        e_line[pick]  <= must_row ? f_row : f_col;
        e_orig[pick]  <= f_row;
      end
      if (alloc_miss) unrep <= 1'b1;
    end
  end

endmodule

// File: rtl/mbr_remap.sv
module mbr_remap #(
  parameter int NSP = 4,
  parameter int LB  = 4,
  parameter int SIW = 2
) (
  input  logic [2*LB-1:0]        h_addr,
  input  logic [NSP-1:0]         e_used,
  input  logic [NSP-1:0]         e_isrow,
  input  logic [NSP-1:0][LB-1:0] e_line,
  output logic                   hit,
  output logic [SIW+LB-1:0]      s_addr
);

  logic [LB-1:0] row;
  logic [LB-1:0] col;

  always_comb begin
    row    = h_addr[2*LB-1:LB];
    col    = h_addr[LB-1:0];
    hit    = 1'b0;
    s_addr = '0;
    // column matches first, lowest index wins
    for (int e = NSP - 1; e >= 0; e--) begin
      if (e_used[e] && !e_isrow[e] && (e_line[e] == col)) begin
        hit    = 1'b1;
        s_addr = {SIW'(e), row};
      end
    end
    // row matches override column matches
    for (int e = NSP - 1; e >= 0; e--) begin
      if (e_used[e] && e_isrow[e] && (e_line[e] == row)) begin
        hit    = 1'b1;
        s_addr = {SIW'(e), col};
      end
    end
  end

endmodule

// File: rtl/mbist_repair.sv
module mbist_repair #(
  parameter int LINE_BITS = 4,
  parameter int DW        = 8,
  parameter int NSPARE    = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                host_req,
  input  logic                                host_we,
  input  logic [2*LINE_BITS-1:0]              host_addr,
  input  logic [DW-1:0]                       host_wdata,
  output logic [DW-1:0]                       host_rdata,
  output logic                                host_rvalid,
  output logic                                host_ready,
  output logic                                irq,
  input  logic                                irq_clr,
  output logic                                st_done,
  output logic                                st_pass,
  output logic                                st_repaired,
  output logic                                st_unrep,
  output logic [$clog2(NSPARE):0]             st_used,
  output logic [2*LINE_BITS-1:0]              mem_addr,
  output logic                                mem_we,
  output logic [DW-1:0]                       mem_wdata,
  input  logic [DW-1:0]                       mem_rdata,
  output logic [$clog2(NSPARE)+LINE_BITS-1:0] spr_addr,
  output logic                                spr_we,
  output logic [DW-1:0]                       spr_wdata,
  input  logic [DW-1:0]                       spr_rdata
);
  import mbr_pkg::*;

  localparam int LB  = LINE_BITS;
  localparam int SIW = $clog2(NSPARE);
  localparam int AW  = 2 * LB;
  localparam int SAW = SIW + LB;
  localparam int UW  = SIW + 1;

  phase_e                 phase;
  logic [AW-1:0]          t_addr;
  logic                   t_we;
  logic                   t_rd;
  logic                   t_val;
  logic                   t_end;
  logic                   done;
  logic [DW-1:0]          test_rdata;
  logic                   test_fail;
  logic                   spr_fail;
  logic                   main_fail;
  logic                   host_go;
  logic                   hit;
  logic [SAW-1:0]         map_addr;
  logic [NSPARE-1:0]      e_used;
  logic [NSPARE-1:0]      e_isrow;
  logic [NSPARE-1:0][LB-1:0] e_line;
  logic                   alloc_fire;
  logic                   alloc_miss;
  logic                   unrep;

  mbr_march_seq #(.AW(AW), .SAW(SAW)) u_seq (
    .clk(clk), .rst_n(rst_n), .t_addr(t_addr), .t_we(t_we), .t_rd(t_rd),
    .t_val(t_val), .phase(phase), .t_end(t_end)
  );

  always_comb begin
    done       = phase == PH_DONE;
    test_rdata = (phase == PH_SPARE) ? spr_rdata : mem_rdata;
    test_fail  = t_rd && (test_rdata != {DW{t_val}});
    spr_fail   = test_fail && (phase == PH_SPARE);
    main_fail  = test_fail && (phase == PH_MAIN);
  end

  mbr_spare_alloc #(.NSP(NSPARE), .LB(LB), .SIW(SIW)) u_alloc (
    .clk(clk), .rst_n(rst_n),
    .spr_fail(spr_fail), .spr_fail_elem(t_addr[SAW-1:LB]),
    .main_fail(main_fail), .f_row(t_addr[AW-1:LB]), .f_col(t_addr[LB-1:0]),
    .e_used(e_used), .e_isrow(e_isrow), .e_line(e_line),
    .alloc_fire(alloc_fire), .alloc_miss(alloc_miss), .unrep(unrep)
  );

  mbr_remap #(.NSP(NSPARE), .LB(LB), .SIW(SIW)) u_remap (
    .h_addr(host_addr), .e_used(e_used), .e_isrow(e_isrow), .e_line(e_line),
    .hit(hit), .s_addr(map_addr)
  );

  // Memory-side steering: the test owns both memories until done
  always_comb begin
    host_go   = host_req && done;
    mem_addr  = done ? host_addr : t_addr;
    spr_addr  = done ? map_addr : t_addr[SAW-1:0];
    mem_we    = done ? (host_go && host_we && !hit) : (t_we && (phase == PH_MAIN));
    spr_we    = done ? (host_go && host_we && hit)  : (t_we && (phase == PH_SPARE));
    mem_wdata = done ? host_wdata : {DW{t_val}};
    spr_wdata = mem_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
      irq         <= 1'b0;
    end else begin
      host_rvalid <= host_go && !host_we;
      if (host_go && !host_we) host_rdata <= hit ? spr_rdata : mem_rdata;
      if (t_end)        irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  always_comb begin
    host_ready  = done;
    st_done     = done;
    st_unrep    = unrep;
    st_pass     = done && !unrep;
    st_used     = UW'($countones(e_used));
    st_repaired = st_used != '0;
  end

endmodule

// File: rtl/mbr_chk.sv
module mbr_chk #(
  parameter int UW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_req,
  input logic          host_ready,
  input logic          host_rvalid,
  input logic          mem_we,
  input logic          spr_we,
  input logic          st_done,
  input logic          st_pass,
  input logic          st_unrep,
  input logic [UW-1:0] st_used,
  input logic          irq,
  input logic          irq_clr,
  input logic          alloc_fire,
  input logic          alloc_miss
);

  // R1
  closed_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_done |-> !host_ready);

  // R1
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |=> st_done);

  // R3
  busy_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_ready) |=> !host_rvalid);

  // R10
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && spr_we));

  // R4
  alloc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> (st_used == $past(st_used) + 1'b1));

  // R6
  alloc_in_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire || alloc_miss) |-> !st_done);

  // R7
  miss_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_miss |=> st_unrep);

  // R7
  unrep_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_unrep |=> st_unrep);

  // R8
  pass_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |-> (st_pass == !st_unrep));

  // R9
  irq_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> irq);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

endmodule

bind mbist_repair mbr_chk #(.UW($clog2(NSPARE) + 1)) u_mbr_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_ready(host_ready),
  .host_rvalid(host_rvalid), .mem_we(mem_we), .spr_we(spr_we),
  .st_done(st_done), .st_pass(st_pass), .st_unrep(st_unrep), .st_used(st_used),
  .irq(irq), .irq_clr(irq_clr), .alloc_fire(alloc_fire), .alloc_miss(alloc_miss)
);

// File: tb/test_mbist_repair.sv
`timescale 1ns/1ps
module test_mbist_repair;
  localparam int LB       = 4;
  localparam int DW       = 8;
  localparam int NSP      = 4;
  localparam int AW       = 2 * LB;
  localparam int SAW      = 2 + LB;
  localparam int TEST_CYC = 10 * (NSP * (2**LB) + (2**AW));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          host_req = 1'b0, host_we = 1'b0, irq_clr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata, mem_wdata, spr_wdata, mem_rdata, spr_rdata;
  logic          host_rvalid, host_ready, irq, st_done, st_pass, st_repaired, st_unrep;
  logic [2:0]    st_used;
  logic [AW-1:0] mem_addr;
  logic [SAW-1:0] spr_addr;
  logic          mem_we, spr_we;

  mbist_repair #(.LINE_BITS(LB), .DW(DW), .NSPARE(NSP)) i_mbist_repair (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .host_ready(host_ready), .irq(irq), .irq_clr(irq_clr),
    .st_done(st_done), .st_pass(st_pass), .st_repaired(st_repaired),
    .st_unrep(st_unrep), .st_used(st_used), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .spr_addr(spr_addr),
    .spr_we(spr_we), .spr_wdata(spr_wdata), .spr_rdata(spr_rdata)
  );

  // Memory model with stuck-at-1 bits
  logic [DW-1:0] mmem [2**AW];
  logic [DW-1:0] mflt [2**AW];
  logic [DW-1:0] smem [2**SAW];
  logic [DW-1:0] sflt [2**SAW];
  assign mem_rdata = mmem[mem_addr] | mflt[mem_addr];
  assign spr_rdata = smem[spr_addr] | sflt[spr_addr];
  always @(posedge clk) begin
    if (mem_we) mmem[mem_addr] <= mem_wdata;
    if (spr_we) smem[spr_addr] <= spr_wdata;
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected read data actual=%0h expected=none", host_rdata);
      end else begin
        string         t;
        logic [DW-1:0] e;
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        if (host_rdata !== e) begin
          errors++;
          $display("FAIL %s read actual=%0h expected=%0h", t, host_rdata, e);
        end
      end
    end
  end

  task automatic host_rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    host_req = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic host_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic to_spare, input logic [SAW-1:0] sa, input string tag);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    #1;
    chk({tag, " spr_we"}, spr_we, to_spare);
    chk({tag, " mem_we"}, mem_we, !to_spare);
    if (to_spare) chk({tag, " spr_addr"}, spr_addr, sa);
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic clear_faults();
    for (int i = 0; i < 2**AW; i++) mflt[i] = '0;
    for (int i = 0; i < 2**SAW; i++) sflt[i] = '0;
  endtask

  // Reset, run the self-test, poke the closed host port, count cycles
  task automatic run_test(input string name);
    int  cyc;
    logic saw_ready;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    saw_ready = 1'b0;
    while (!st_done && cyc < TEST_CYC + 50) begin
      if (cyc == 100) begin host_req = 1'b1; host_we = 1'b1; host_addr = 8'h42; host_wdata = 8'hA5; end
      if (cyc == 101) host_we = 1'b0;
      if (cyc == 102) host_req = 1'b0;
      @(negedge clk);
      cyc++;
      if (!st_done && (host_ready || irq)) saw_ready = 1'b1;
    end
    chk({"R1 test length ", name}, cyc, TEST_CYC);
    chk({"R3 port closed during test ", name}, saw_ready, 1'b0);
    chk({"R9 irq with done ", name}, irq, 1'b1);
    host_rd(8'h42, 8'h00, {"R3 busy write dropped ", name});
  endtask

  initial begin
    clear_faults();
    @(negedge clk);
    chk("reset st_done", st_done, 1'b0);
    chk("reset irq", irq, 1'b0);
    chk("reset host_ready", host_ready, 1'b0);
    chk("reset st_used", st_used, 3'd0);

    // Fault-free memory
    run_test("clean");
    chk("R8 pass clean", st_pass, 1'b1);
    chk("R8 repaired clean", st_repaired, 1'b0);
    chk("R8 used clean", st_used, 3'd0);
    host_wr(8'h10, 8'h3C, 1'b0, '0, "R10 plain write");
    host_rd(8'h10, 8'h3C, "R10 plain read");
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R9 irq cleared", irq, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9 irq stays clear", irq, 1'b0);

    // One stuck cell at row 3, col 5: column spare 0
    clear_faults();
    mflt[8'h35] = 8'h01;
    run_test("single");
    chk("R6 used single", st_used, 3'd1);
    chk("R8 repaired single", st_repaired, 1'b1);
    chk("R8 pass single", st_pass, 1'b1);
    host_wr(8'h35, 8'h5A, 1'b1, 6'd3, "R4 col remap r3");
    host_rd(8'h35, 8'h5A, "R4 col remap read");
    host_wr(8'h75, 8'h66, 1'b1, 6'd7, "R4 col remap r7");
    host_rd(8'h75, 8'h66, "R4 col remap read r7");
    host_wr(8'h36, 8'h11, 1'b0, '0, "R10 neighbour unmapped");
    host_rd(8'h36, 8'h11, "R10 neighbour read");

    // Two faults in row 2: column spare for col 1, then row spare for row 2
    clear_faults();
    mflt[8'h21] = 8'h01;
    mflt[8'h29] = 8'h01;
    run_test("row");
    chk("R5 used two", st_used, 3'd2);
    host_wr(8'h24, 8'h77, 1'b1, 6'd20, "R5 row remap");
    host_wr(8'h21, 8'h88, 1'b1, 6'd17, "R5 row beats column");
    host_wr(8'h61, 8'h99, 1'b1, 6'd6, "R4 column spare elem0");
    host_rd(8'h24, 8'h77, "R5 row read");
    host_rd(8'h21, 8'h88, "R5 cross read");
    host_rd(8'h61, 8'h99, "R4 column read");

    // Bad spare element 0: fault goes to element 1
    clear_faults();
    sflt[7] = 8'h01;
    mflt[8'h35] = 8'h01;
    run_test("badspare");
    chk("R2 used badspare", st_used, 3'd1);
    host_wr(8'h35, 8'hC3, 1'b1, 6'd19, "R2 skip bad spare");
    host_rd(8'h35, 8'hC3, "R2 skip bad spare read");

    // Five diagonal faults exhaust the pool
    clear_faults();
    for (int i = 0; i < 5; i++) mflt[(i << 4) | i] = 8'h01;
    run_test("exhaust");
    chk("R7 unrep", st_unrep, 1'b1);
    chk("R7 pass low", st_pass, 1'b0);
    chk("R8 used all", st_used, 3'd4);

    // Clean run again: repair state is rebuilt
    clear_faults();
    run_test("rebuild");
    chk("R11 used after reset", st_used, 3'd0);
    chk("R11 unrep after reset", st_unrep, 1'b0);
    host_wr(8'h35, 8'h12, 1'b0, '0, "R11 no stale remap");

    @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule